// File: doc/BRIEF.md
# Double-Banked Bulk Packet Buffer

This block stages bulk endpoint traffic between a storage-side producer and a USB-side consumer. It holds two equal banks. The producer fills one bank while the consumer empties the other. Ownership of each bank changes hands once per packet. The same block serves either transfer direction. For device-to-host traffic the storage engine is the producer. For host-to-device traffic the USB engine is the producer. Control traffic uses its own storage and never passes through here.

A speed input sets the packet limit: 512 bytes when high speed is selected, 64 bytes at full speed. A bank is handed to the consumer in one of two ways. It goes automatically when it reaches the packet limit, or earlier when the producer commits a short packet. A commit with no data marks a zero-length packet. The byte count of a bank is frozen when it is committed. The consumer reads the bytes in order. It then acknowledges, and the bank returns to the producer. A flush input takes back both banks at once.

Top module: `pp_bulk_buf`

## Requirements
- R1: After reset both banks belong to the producer with zero counts: `bank_full`=00, `bank_empty`=11, `prod_ready`=1, `cons_pkt_avail`=0.
- R2: With `hs_mode`=1, accepting the 512th byte of a bank commits it. One edge later its `bank_full` bit is 1 and its count reads 512.
- R3: With `hs_mode`=0, accepting the 64th byte of a bank commits it. One edge later its `bank_full` bit is 1 and its count reads 64.
- R4: A `prod_commit` pulse commits the bank being filled with its current count. A byte accepted in the same cycle is included. A commit with no bytes yields a packet with `cons_len`=0 and `cons_valid`=0.
- R5: Commits alternate between banks, starting with bank 0 after reset or flush. The consumer drains the banks in the same order and sees the bytes in write order.
- R6: `prod_ready` is 0 whenever both banks are committed. It is also 0 whenever the fill count is at or above the current packet limit.
- R7: `cons_pkt_avail` is 0 when no bank is committed. `cons_valid` is 1 only while unread bytes remain. `cons_last` is 1 on the final byte of a packet.
- R8: `cons_ack` returns the draining bank to the producer, with its count cleared, only if every byte was read in earlier cycles. Otherwise it is ignored, and the packet and its count stay as they were.
- R9: `flush` overrides a write or commit in the same cycle. It restores the R1 state, including the bank order.
- R10: A `prod_valid` while `prod_ready`=0 stores nothing, and no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_mode | input | 1 | 1 = 512-byte packet limit, 0 = 64-byte limit |
| flush | input | 1 | Return both banks to the producer and clear counts |
| prod_valid | input | 1 | Producer offers a byte |
| prod_data | input | 8 | Producer byte |
| prod_commit | input | 1 | Commit current bank as a (short or empty) packet |
| prod_ready | output | 1 | Producer byte will be accepted |
| cons_ready | input | 1 | Consumer takes the presented byte |
| cons_ack | input | 1 | Consumer releases the fully read packet |
| cons_data | output | 8 | Byte at the consumer read position |
| cons_valid | output | 1 | `cons_data` holds an unread byte |
| cons_last | output | 1 | Presented byte is the packet's last |
| cons_pkt_avail | output | 1 | A committed packet is at the consumer |
| cons_len | output | 10 | Byte count of the packet being drained |
| bank_full | output | 2 | Per bank: committed to the consumer |
| bank_empty | output | 2 | Per bank: producer-owned and holding no bytes |
| bank_cnt0 | output | 10 | Byte count of bank 0 |
| bank_cnt1 | output | 10 | Byte count of bank 1 |

## Verification
The ready, valid, data, last and length outputs are decoded directly from registered state, so they are valid in the cycle the stimulus is applied. Counts, flags and ownership move one rising edge after an accepted write, read, commit, acknowledge or flush. The bench changes inputs on the falling edge and reads results on the next falling edge, after exactly one rising edge. The one exception is the speed-limit check. There it changes `hs_mode` and reads `prod_ready` a moment later, before any edge.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;

    typedef enum logic {
        OWN_PROD = 1'b0,
        OWN_CONS = 1'b1
    } owner_e;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/pp_bank_store.sv
module pp_bank_store #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned BANK_BYTES = 512,
    localparam int unsigned AW        = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    import pp_buf_pkg::*;

    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [DATA_W-1:0] mem [BANK_BYTES];

        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(g))) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_rd[g] = mem[raddr];
    end

    assign rdata = bank_rd[rbank];

endmodule

// File: rtl/pp_bank_ctrl.sv
module pp_bank_ctrl #(
    parameter int unsigned BANK_BYTES = 512,
    parameter int unsigned HS_PKT     = 512,
    parameter int unsigned FS_PKT     = 64,
    localparam int unsigned AW        = $clog2(BANK_BYTES),
    localparam int unsigned CNT_W     = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_mode,
    input  logic             flush,
    input  logic             prod_valid,
    input  logic             prod_commit,
    input  logic             cons_ready,
    input  logic             cons_ack,
    output logic             prod_ready,
    output logic             wr_en,
    output logic             wr_bank,
    output logic [AW-1:0]    wr_addr,
    output logic             rd_bank,
    output logic [AW-1:0]    rd_addr,
    output logic             cons_valid,
    output logic             cons_last,
    output logic             cons_pkt_avail,
    output logic [CNT_W-1:0] cons_len,
    output logic [1:0]       bank_full,
    output logic [1:0]       bank_empty,
    output logic [CNT_W-1:0] bank_cnt0,
    output logic [CNT_W-1:0] bank_cnt1
);
    import pp_buf_pkg::*;

    typedef struct packed {
        owner_e [1:0]            own;
        logic [1:0][CNT_W-1:0]   cnt;
        logic                    fill;
        logic                    drain;
        logic [CNT_W-1:0]        rd_ptr;
    } ctrl_st_t;

    localparam ctrl_st_t ST_RST = '0;

    ctrl_st_t st_d, st_q;

    logic [CNT_W-1:0] pkt_lim;
    logic [CNT_W-1:0] fill_cnt;
    logic             fill_free;
    logic             rd_en;
    logic             do_commit;
    logic             ack_ok;

    assign pkt_lim        = hs_mode ? CNT_W'(HS_PKT) : CNT_W'(FS_PKT);
    assign fill_cnt       = st_q.cnt[st_q.fill];
    assign fill_free      = (st_q.own[st_q.fill] == OWN_PROD);
    assign prod_ready     = fill_free && (fill_cnt < pkt_lim);
    assign wr_en          = prod_valid && prod_ready;
    assign wr_bank        = st_q.fill;
    assign wr_addr        = fill_cnt[AW-1:0];

    assign cons_pkt_avail = (st_q.own[st_q.drain] == OWN_CONS);
    assign cons_len       = st_q.cnt[st_q.drain];
    assign cons_valid     = cons_pkt_avail && (st_q.rd_ptr < cons_len);
    assign cons_last      = cons_valid && (st_q.rd_ptr == cons_len - CNT_W'(1));
    assign rd_bank        = st_q.drain;
    assign rd_addr        = st_q.rd_ptr[AW-1:0];
    assign rd_en          = cons_valid && cons_ready;

    assign do_commit      = fill_free &&
                            (prod_commit || (wr_en && (fill_cnt + CNT_W'(1) == pkt_lim)));
    assign ack_ok         = cons_ack && cons_pkt_avail && (st_q.rd_ptr == cons_len);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt[st_q.fill] = fill_cnt + CNT_W'(1);
        end
        if (rd_en) begin
            st_d.rd_ptr = st_q.rd_ptr + CNT_W'(1);
        end
        if (do_commit) begin
            st_d.own[st_q.fill] = OWN_CONS;
            st_d.fill           = ~st_q.fill;
        end
        if (ack_ok) begin
            st_d.own[st_q.drain] = OWN_PROD;
            st_d.cnt[st_q.drain] = '0;
            st_d.drain           = ~st_q.drain;
            st_d.rd_ptr          = '0;
        end
        if (flush) begin
            st_d = ST_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flags
        assign bank_full[b]  = (st_q.own[b] == OWN_CONS);
        assign bank_empty[b] = (st_q.own[b] == OWN_PROD) && (st_q.cnt[b] == '0);
    end

    assign bank_cnt0 = st_q.cnt[0];
    assign bank_cnt1 = st_q.cnt[1];

endmodule

// File: rtl/pp_bulk_buf.sv
module pp_bulk_buf #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned BANK_BYTES = 512,
    parameter int unsigned HS_PKT     = 512,
    parameter int unsigned FS_PKT     = 64,
    localparam int unsigned AW        = $clog2(BANK_BYTES),
    localparam int unsigned CNT_W     = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_mode,
    input  logic              flush,
    input  logic              prod_valid,
    input  logic [DATA_W-1:0] prod_data,
    input  logic              prod_commit,
    output logic              prod_ready,
    input  logic              cons_ready,
    input  logic              cons_ack,
    output logic [DATA_W-1:0] cons_data,
    output logic              cons_valid,
    output logic              cons_last,
    output logic              cons_pkt_avail,
    output logic [CNT_W-1:0]  cons_len,
    output logic [1:0]        bank_full,
    output logic [1:0]        bank_empty,
    output logic [CNT_W-1:0]  bank_cnt0,
    output logic [CNT_W-1:0]  bank_cnt1
);
    logic          wr_en;
    logic          wr_bank;
    logic [AW-1:0] wr_addr;
    logic          rd_bank;
    logic [AW-1:0] rd_addr;

    pp_bank_ctrl #(
        .BANK_BYTES (BANK_BYTES),
        .HS_PKT     (HS_PKT),
        .FS_PKT     (FS_PKT)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .hs_mode        (hs_mode),
        .flush          (flush),
        .prod_valid     (prod_valid),
        .prod_commit    (prod_commit),
        .cons_ready     (cons_ready),
        .cons_ack       (cons_ack),
        .prod_ready     (prod_ready),
        .wr_en          (wr_en),
        .wr_bank        (wr_bank),
        .wr_addr        (wr_addr),
        .rd_bank        (rd_bank),
        .rd_addr        (rd_addr),
        .cons_valid     (cons_valid),
        .cons_last      (cons_last),
        .cons_pkt_avail (cons_pkt_avail),
        .cons_len       (cons_len),
        .bank_full      (bank_full),
        .bank_empty     (bank_empty),
        .bank_cnt0      (bank_cnt0),
        .bank_cnt1      (bank_cnt1)
    );

    pp_bank_store #(
        .DATA_W     (DATA_W),
        .BANK_BYTES (BANK_BYTES)
    ) u_store (
        .clk   (clk),
        .we    (wr_en),
        .wbank (wr_bank),
        .waddr (wr_addr),
        .wdata (prod_data),
        .rbank (rd_bank),
        .raddr (rd_addr),
        .rdata (cons_data)
    );

endmodule

// File: rtl/pp_bulk_buf_chk.sv
module pp_bulk_buf_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             cons_ack,
    input logic             prod_ready,
    input logic             cons_valid,
    input logic             cons_last,
    input logic             cons_pkt_avail,
    input logic [CNT_W-1:0] cons_len,
    input logic [1:0]       bank_full,
    input logic [1:0]       bank_empty,
    input logic [CNT_W-1:0] bank_cnt0,
    input logic [CNT_W-1:0] bank_cnt1
);

    a_r6_stall_both_full: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_full == 2'b11) |-> !prod_ready);

    a_r7_no_pkt_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        !cons_pkt_avail |-> !cons_valid);

    a_r7_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cons_last |-> cons_valid);

    a_r9_flush_restores: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (bank_full == 2'b00) && (bank_empty == 2'b11) &&
                  (bank_cnt0 == '0) && (bank_cnt1 == '0));

    a_r8_early_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_ack && cons_valid && !flush) |=> cons_pkt_avail && $stable(cons_len));

    a_r4_len_frozen_b0: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_full[0] && !flush) |=> (!bank_full[0] || $stable(bank_cnt0)));

    a_r4_len_frozen_b1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_full[1] && !flush) |=> (!bank_full[1] || $stable(bank_cnt1)));

endmodule

bind pp_bulk_buf pp_bulk_buf_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .cons_ack       (cons_ack),
    .prod_ready     (prod_ready),
    .cons_valid     (cons_valid),
    .cons_last      (cons_last),
    .cons_pkt_avail (cons_pkt_avail),
    .cons_len       (cons_len),
    .bank_full      (bank_full),
    .bank_empty     (bank_empty),
    .bank_cnt0      (bank_cnt0),
    .bank_cnt1      (bank_cnt1)
);

// File: tb/pp_bulk_buf_bench.sv
`timescale 1ns/1ps
module pp_bulk_buf_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hs_mode, flush, prod_valid, prod_commit, cons_ready, cons_ack;
    logic [7:0] prod_data;
    logic       prod_ready, cons_valid, cons_last, cons_pkt_avail;
    logic [7:0] cons_data;
    logic [9:0] cons_len, bank_cnt0, bank_cnt1;
    logic [1:0] bank_full, bank_empty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pp_bulk_buf u_pp_bulk_buf (
        .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .flush(flush),
        .prod_valid(prod_valid), .prod_data(prod_data), .prod_commit(prod_commit),
        .prod_ready(prod_ready), .cons_ready(cons_ready), .cons_ack(cons_ack),
        .cons_data(cons_data), .cons_valid(cons_valid), .cons_last(cons_last),
        .cons_pkt_avail(cons_pkt_avail), .cons_len(cons_len),
        .bank_full(bank_full), .bank_empty(bank_empty),
        .bank_cnt0(bank_cnt0), .bank_cnt1(bank_cnt1)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] v, input logic with_commit);
        prod_valid  = 1'b1;
        prod_data   = v;
        prod_commit = with_commit;
        @(negedge clk);
        prod_valid  = 1'b0;
        prod_commit = 1'b0;
    endtask

    task automatic push_run(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) push(8'(base + i), 1'b0);
    endtask

    task automatic pulse_commit();
        prod_commit = 1'b1;
        @(negedge clk);
        prod_commit = 1'b0;
    endtask

    task automatic pulse_ack();
        cons_ack = 1'b1;
        @(negedge clk);
        cons_ack = 1'b0;
    endtask

    // Drain a packet, checking order (R5) and framing (R7), then release it (R8)
    task automatic drain_pkt(input int len, input logic [7:0] base);
        chk("R7 pkt available", int'(cons_pkt_avail), 1);
        chk("R4 latched length", int'(cons_len), len);
        for (int i = 0; i < len; i++) begin
            cons_ready = 1'b1;
            chk("R7 byte valid", int'(cons_valid), 1);
            chk("R5 byte order", int'(cons_data), int'(8'(base + i)));
            chk("R7 last marker", int'(cons_last), int'(i == len - 1));
            @(negedge clk);
        end
        cons_ready = 1'b0;
        chk("R7 no byte after end", int'(cons_valid), 0);
        pulse_ack();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hs_mode = 1'b1; flush = 1'b0; prod_valid = 1'b0;
        prod_commit = 1'b0; cons_ready = 1'b0; cons_ack = 1'b0; prod_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bank_full", int'(bank_full), 0);
        chk("R1 bank_empty", int'(bank_empty), 3);
        chk("R1 prod_ready", int'(prod_ready), 1);
        chk("R1 cons_pkt_avail", int'(cons_pkt_avail), 0);
    endtask

    task automatic t_full_speed();
        hs_mode = 1'b0;
        push_run(63, 8'h10);
        chk("R3 not yet committed", int'(bank_full), 0);
        push(8'h4F, 1'b0);
        chk("R3 bank0 committed at 64", int'(bank_full), 1);
        chk("R3 bank0 count", int'(bank_cnt0), 64);
        chk("R5 bank1 next to fill", int'(bank_empty), 2);
        chk("R6 ready with one bank free", int'(prod_ready), 1);
        drain_pkt(64, 8'h10);
        chk("R8 bank0 released", int'(bank_full), 0);
        chk("R8 bank0 count cleared", int'(bank_empty), 3);
    endtask

    task automatic t_high_speed();
        hs_mode = 1'b1;
        push_run(511, 8'h40);
        chk("R2 not committed at 511", int'(bank_full), 0);
        chk("R5 bank1 filled second", int'(bank_cnt1), 511);
        push(8'(8'h40 + 511), 1'b0);
        chk("R2 bank1 committed at 512", int'(bank_full), 2);
        chk("R2 bank1 count", int'(bank_cnt1), 512);
        drain_pkt(512, 8'h40);
        chk("R8 bank1 released", int'(bank_full), 0);
    endtask

    task automatic t_short_and_zero();
        push_run(5, 8'hA0);
        push(8'hA5, 1'b1);
        chk("R4 short commit", int'(bank_full), 1);
        chk("R4 short count with same-cycle byte", int'(bank_cnt0), 6);
        pulse_commit();
        chk("R4 zero-length commit", int'(bank_full), 3);
        chk("R4 zero-length count", int'(bank_cnt1), 0);
        chk("R6 stalled both full", int'(prod_ready), 0);
        prod_valid = 1'b1; prod_data = 8'hFF;
        repeat (2) @(negedge clk);
        prod_valid = 1'b0;
        chk("R10 bank0 unchanged", int'(bank_cnt0), 6);
        chk("R10 bank1 unchanged", int'(bank_cnt1), 0);
        cons_ready = 1'b1;
        repeat (2) @(negedge clk);
        cons_ready = 1'b0;
        pulse_ack();
        chk("R8 early ack keeps packet", int'(cons_pkt_avail), 1);
        chk("R8 early ack keeps length", int'(cons_len), 6);
        chk("R8 early ack keeps banks", int'(bank_full), 3);
        chk("R8 read position kept", int'(cons_data), 8'hA2);
        for (int i = 2; i < 6; i++) begin
            cons_ready = 1'b1;
            chk("R5 remaining bytes", int'(cons_data), int'(8'(8'hA0 + i)));
            @(negedge clk);
        end
        cons_ready = 1'b0;
        pulse_ack();
        chk("R8 bank0 freed", int'(bank_full), 2);
        chk("R6 ready again", int'(prod_ready), 1);
        chk("R4 zlp available", int'(cons_pkt_avail), 1);
        chk("R4 zlp length", int'(cons_len), 0);
        chk("R4 zlp has no byte", int'(cons_valid), 0);
        pulse_ack();
        chk("R8 zlp released", int'(bank_full), 0);
    endtask

    task automatic t_flush();
        push(8'h01, 1'b0); push(8'h02, 1'b0); push(8'h03, 1'b1);
        push(8'h04, 1'b0); push(8'h05, 1'b0);
        chk("R9 setup bank0 full", int'(bank_full), 1);
        chk("R9 setup bank1 count", int'(bank_cnt1), 2);
        flush = 1'b1; prod_valid = 1'b1; prod_commit = 1'b1; prod_data = 8'h66;
        @(negedge clk);
        flush = 1'b0; prod_valid = 1'b0; prod_commit = 1'b0;
        chk("R9 full cleared", int'(bank_full), 0);
        chk("R9 empty restored", int'(bank_empty), 3);
        chk("R9 count0", int'(bank_cnt0), 0);
        chk("R9 count1", int'(bank_cnt1), 0);
        chk("R9 no packet", int'(cons_pkt_avail), 0);
        chk("R1 ready after flush", int'(prod_ready), 1);
        push(8'h77, 1'b1);
        chk("R9 order restarts at bank0", int'(bank_full), 1);
        drain_pkt(1, 8'h77);
    endtask

    task automatic t_speed_limit();
        hs_mode = 1'b1;
        push_run(100, 8'h30);
        chk("R6 ready below limit", int'(prod_ready), 1);
        chk("R5 bank1 count", int'(bank_cnt1), 100);
        hs_mode = 1'b0;
        #1;
        chk("R6 ready drops above limit", int'(prod_ready), 0);
        @(negedge clk);
        pulse_commit();
        chk("R4 commit above limit", int'(bank_full), 2);
        chk("R4 count kept", int'(bank_cnt1), 100);
        drain_pkt(100, 8'h30);
        hs_mode = 1'b1;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        t_reset();
        t_full_speed();
        t_high_speed();
        t_short_and_zero();
        t_flush();
        t_speed_limit();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

endmodule